// File: doc/BRIEF.md
# Flow-Through Synchronous SRAM Access Controller

This block is the control and data path of a synchronous static RAM organised as words of two 9-bit byte lanes (8 data bits and 1 parity bit per lane). On each rising clock edge it registers the access: address, chip-select qualification, write controls and write data. Read data leaves the storage array without an output register. The word addressed by the access captured at an edge is therefore on the data output during the clock period that follows that same edge.

A load strobe brings in a full external address and samples the three chip enables. On the cycles between loads, the lowest address bits come from an external sequencing counter, and the upper bits and the selection are held. A global write forces both lanes to be written. Otherwise a byte-write qualifier together with per-lane enables picks which lanes change.

The shared data bus is modelled as separate input, output and output-enable signals. The output enable turns off at once when the asynchronous output-enable pin goes high, when the sleep input is high, or while a write is in progress.

Top module: `fts_sram_ctrl`

## Requirements
- R1: While reset is held, and until the first selecting load after reset, `dq_oe` is 0 and `dq_o` is all zeros.
- R2: A cycle with `adr_ld`=1 selects the block only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. After a load with any other combination, the block neither drives the bus nor writes the array until the next selecting load.
- R3: On cycles with `adr_ld`=0, the chip-enable inputs are ignored and the selection made by the last load is kept.
- R4: When `gw_n`=0, both lanes of the addressed word are written from `dq_i`, whatever `bwe_n` and `bw_n` are.
- R5: With `gw_n`=1 and `bwe_n`=0, each lane whose `bw_n` bit is 0 is written, and the other lane keeps its old value. Bit 0 of `bw_n` controls lane A, which is `dq` bits 8:0. Bit 1 controls lane B, which is bits 17:9.
- R6: With `gw_n`=1, a cycle is a read when either `bwe_n`=1, or `bwe_n`=0 with both `bw_n` bits 1. The array is then left unchanged.
- R7: Read data for the access registered at edge k is on `dq_o` during the period after edge k. A write registered at edge k can be read back by an access registered at edge k+1.
- R8: During a write cycle `dq_oe` is 0 whatever the state of `oe_n`.
- R9: `dq_oe` follows `oe_n` without waiting for a clock edge. Whenever `dq_oe` is 0, `dq_o` is all zeros.
- R10: `sleep`=1 forces `dq_oe` to 0 at once. An edge that samples `sleep`=1 deselects the block. After `sleep` returns to 0 the bus stays off until a new selecting load.
- R11: A load uses all bits of `adr_in`. Cycles with `adr_ld`=0 address the word formed by the registered upper bits and the low `BURST_W` bits taken from `seq_ofs`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adr_ld | input | 1 | Load a new external address and sample chip enables |
| adr_in | input | ADDR_W | External word address |
| seq_ofs | input | BURST_W | Low address bits from the sequencing counter |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write qualifier, active low |
| bw_n | input | 2 | Per-lane write enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Sleep request, forces bus off |
| dq_i | input | 18 | Write data |
| dq_o | output | 18 | Read data, zero when not driven |
| dq_oe | output | 1 | Bus drive enable |

## Verification
Two functions can fall in the same cycle. The asynchronous bus gating (output enable and sleep) can coincide with a selected read or with a registered write. A write can also be followed at once by a read of the same word in the next cycle. The stimulus keeps `oe_n` low through random write and read mixes, and flips `oe_n` and `sleep` between clock edges while a read is driving. A bench reference model of the array and the registered access judges every cycle: `dq_oe` must be low in any write or sleeping period, and read data must reflect the write committed one edge earlier.

// File: rtl/fts_sram_pkg.sv
package fts_sram_pkg;
  localparam int LANE_W = 9;
  localparam int LANES  = 2;
  localparam int WORD_W = LANE_W * LANES;

  function automatic logic ce_match(input logic ce1_n, input logic ce2, input logic ce3_n);
    return ~ce1_n & ce2 & ~ce3_n;
  endfunction
endpackage

// File: rtl/fts_rst_sync.sv
module fts_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/fts_wr_decode.sv
module fts_wr_decode #(
  parameter int LANES = 2
) (
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] bw_n,
  output logic [LANES-1:0] lane_req
);
  // Global write overrides; otherwise the qualifier gates each lane enable.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_req[g] = ~gw_n | (~bwe_n & ~bw_n[g]);
  end
endmodule

// File: rtl/fts_acc_reg.sv
module fts_acc_reg #(
  parameter int ADDR_W  = 8,
  parameter int BURST_W = 2,
  parameter int LANES   = 2,
  parameter int WORD_W  = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep,
  input  logic              adr_ld,
  input  logic [ADDR_W-1:0] adr_in,
  input  logic [BURST_W-1:0] seq_ofs,
  input  logic              ce_ok,
  input  logic [LANES-1:0]  lane_req,
  input  logic [WORD_W-1:0] din,
  output logic              sel_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [LANES-1:0]  lanes_q,
  output logic [WORD_W-1:0] din_q
);
  localparam int HI_W = ADDR_W - BURST_W;

  logic              sel_d;
  logic [ADDR_W-1:0] addr_d;
  logic [LANES-1:0]  lanes_d;
  logic              addr_en;
  logic              din_en;

  always_comb begin
    if (sleep)       sel_d = 1'b0;
    else if (adr_ld) sel_d = ce_ok;
    else             sel_d = sel_q;

    if (adr_ld) addr_d = adr_in;
    else        addr_d = {addr_q[ADDR_W-1 -: HI_W], seq_ofs};

    lanes_d = sel_d ? lane_req : '0;
    addr_en = adr_ld | sel_q;
    din_en  = |lanes_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= 1'b0;
      lanes_q <= '0;
      addr_q  <= '0;
      din_q   <= '0;
    end else begin
      sel_q   <= sel_d;
      lanes_q <= lanes_d;
      if (addr_en) addr_q <= addr_d;
      if (din_en)  din_q  <= din;
    end
  end
endmodule

// File: rtl/fts_word_array.sv
module fts_word_array #(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES-1:0]        we,
  input  logic [LANE_W*LANES-1:0] wdata,
  output logic [LANE_W*LANES-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_bank
    logic [LANE_W-1:0] bank [DEPTH];

    always_ff @(posedge clk) begin
      if (we[g]) bank[addr] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rdata[g*LANE_W +: LANE_W] = bank[addr];
  end
endmodule

// File: rtl/fts_sram_ctrl.sv
module fts_sram_ctrl
  import fts_sram_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int BURST_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               adr_ld,
  input  logic [ADDR_W-1:0]  adr_in,
  input  logic [BURST_W-1:0] seq_ofs,
  input  logic               ce1_n,
  input  logic               ce2,
  input  logic               ce3_n,
  input  logic               gw_n,
  input  logic               bwe_n,
  input  logic [LANES-1:0]   bw_n,
  input  logic               oe_n,
  input  logic               sleep,
  input  logic [WORD_W-1:0]  dq_i,
  output logic [WORD_W-1:0]  dq_o,
  output logic               dq_oe
);
  logic              rst_int_n;
  logic [LANES-1:0]  lane_req;
  logic              sel_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LANES-1:0]  lanes_q;
  logic [WORD_W-1:0] din_q;
  logic [WORD_W-1:0] rdata;
  logic [LANES-1:0]  arr_we;
  logic              wr_cycle;

  fts_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  fts_wr_decode #(.LANES(LANES)) u_dec (
    .gw_n     (gw_n),
    .bwe_n    (bwe_n),
    .bw_n     (bw_n),
    .lane_req (lane_req)
  );

  fts_acc_reg #(
    .ADDR_W (ADDR_W),
    .BURST_W(BURST_W),
    .LANES  (LANES),
    .WORD_W (WORD_W)
  ) u_acc (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .sleep    (sleep),
    .adr_ld   (adr_ld),
    .adr_in   (adr_in),
    .seq_ofs  (seq_ofs),
    .ce_ok    (ce_match(ce1_n, ce2, ce3_n)),
    .lane_req (lane_req),
    .din      (dq_i),
    .sel_q    (sel_q),
    .addr_q   (addr_q),
    .lanes_q  (lanes_q),
    .din_q    (din_q)
  );

  assign arr_we = lanes_q & {LANES{sel_q}};

  fts_word_array #(
    .ADDR_W(ADDR_W),
    .LANE_W(LANE_W),
    .LANES (LANES)
  ) u_arr (
    .clk   (clk),
    .addr  (addr_q),
    .we    (arr_we),
    .wdata (din_q),
    .rdata (rdata)
  );

  // Output gating: asynchronous pins act without a clock edge.
  assign wr_cycle = |lanes_q;
  assign dq_oe    = sel_q & ~wr_cycle & ~oe_n & ~sleep;
  assign dq_o     = dq_oe ? rdata : '0;
endmodule

// File: rtl/fts_sram_chk.sv
module fts_sram_chk #(
  parameter int LANES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             adr_ld,
  input logic             ce1_n,
  input logic             ce2,
  input logic             ce3_n,
  input logic             gw_n,
  input logic             bwe_n,
  input logic [LANES-1:0] bw_n,
  input logic             oe_n,
  input logic             sleep,
  input logic             dq_oe
);
  assert_oe_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (!oe_n && !sleep));

  assert_gw_hiz_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !gw_n |=> !dq_oe);

  assert_bytewr_hiz_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (gw_n && !bwe_n && (bw_n != '1)) |=> !dq_oe);

  assert_desel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (adr_ld && !(!ce1_n && ce2 && !ce3_n)) |=> !dq_oe);

  assert_sleep_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> !dq_oe);

  assert_sleep_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep) |-> !dq_oe);
endmodule

bind fts_sram_ctrl fts_sram_chk #(.LANES(fts_sram_pkg::LANES)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .adr_ld (adr_ld),
  .ce1_n  (ce1_n),
  .ce2    (ce2),
  .ce3_n  (ce3_n),
  .gw_n   (gw_n),
  .bwe_n  (bwe_n),
  .bw_n   (bw_n),
  .oe_n   (oe_n),
  .sleep  (sleep),
  .dq_oe  (dq_oe)
);

// File: tb/sim_fts_sram_ctrl.sv
`timescale 1ns/1ps
module sim_fts_sram_ctrl;
  localparam int AW = 8;
  localparam int BW = 2;
  localparam int DEPTH = 1 << AW;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        adr_ld;
  logic [AW-1:0] adr_in;
  logic [BW-1:0] seq_ofs;
  logic        ce1_n, ce2, ce3_n;
  logic        gw_n, bwe_n;
  logic [1:0]  bw_n;
  logic        oe_n, sleep;
  logic [17:0] dq_i;
  logic [17:0] dq_o;
  logic        dq_oe;

  int total = 0;
  int bad   = 0;
  bit finished = 0;
  bit mem_known = 0;

  logic [17:0]   ref_mem [DEPTH];
  logic          m_sel;
  logic [AW-1:0] m_addr;
  logic [1:0]    m_lanes;
  logic [17:0]   m_din;

  always #2 clk = ~clk;

  fts_sram_ctrl #(.ADDR_W(AW), .BURST_W(BW)) u0 (
    .clk(clk), .rst_n(rst_n), .adr_ld(adr_ld), .adr_in(adr_in), .seq_ofs(seq_ofs),
    .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .gw_n(gw_n), .bwe_n(bwe_n),
    .bw_n(bw_n), .oe_n(oe_n), .sleep(sleep), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe)
  );

  function automatic logic [1:0] exp_lanes(logic g, logic b, logic [1:0] e);
    if (!g) return 2'b11;
    if (!b) return ~e;
    return 2'b00;
  endfunction

  function automatic logic [17:0] merge(logic [17:0] old, logic [17:0] nw, logic [1:0] ln);
    logic [17:0] r;
    r = old;
    if (ln[0]) r[8:0]  = nw[8:0];
    if (ln[1]) r[17:9] = nw[17:9];
    return r;
  endfunction

  task automatic check_bus(string tag);
    logic        eoe;
    logic [17:0] edq;
    eoe = m_sel && (m_lanes == 2'b00) && !oe_n && !sleep;
    total++;
    if (dq_oe !== eoe) begin
      bad++;
      $display("FAIL %s: dq_oe actual=%b expected=%b", tag, dq_oe, eoe);
    end
    if (!eoe || mem_known) begin
      edq = eoe ? ref_mem[m_addr] : 18'h0;
      total++;
      if (dq_o !== edq) begin
        bad++;
        $display("FAIL %s: dq_o actual=%h expected=%h", tag, dq_o, edq);
      end
    end
  endtask

  // One clock: edge, reference update, check after settling, back at negedge.
  task automatic tick(string tag);
    @(posedge clk);
    if (m_sel && (m_lanes != 2'b00)) ref_mem[m_addr] = merge(ref_mem[m_addr], m_din, m_lanes);
    if (sleep)       m_sel = 1'b0;
    else if (adr_ld) m_sel = !ce1_n && ce2 && !ce3_n;
    if (adr_ld)      m_addr = adr_in;
    else if (m_sel)  m_addr = {m_addr[AW-1:BW], seq_ofs};
    m_lanes = m_sel ? exp_lanes(gw_n, bwe_n, bw_n) : 2'b00;
    if (m_lanes != 2'b00) m_din = dq_i;
    #1;
    check_bus(tag);
    @(negedge clk);
  endtask

  task automatic idle_in();
    adr_ld = 0; adr_in = '0; seq_ofs = '0;
    ce1_n = 0; ce2 = 1; ce3_n = 0;
    gw_n = 1; bwe_n = 1; bw_n = 2'b11;
    oe_n = 0; sleep = 0; dq_i = '0;
  endtask

  task automatic load_read(logic [AW-1:0] a, string tag);
    idle_in(); adr_ld = 1; adr_in = a;
    tick(tag);
    adr_ld = 0;
  endtask

  initial begin
    #(4 * 190000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: run did not end, actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0a17));
    idle_in();
    rst_n = 0;
    m_sel = 0; m_addr = '0; m_lanes = '0; m_din = '0;
    repeat (3) @(posedge clk);
    #1;
    check_bus("R1 in reset");
    @(negedge clk); rst_n = 1;
    repeat (4) @(negedge clk);
    #0.5;
    check_bus("R1 after reset");

    // Fill the array with global writes (R4), one load per word.
    for (int a = 0; a < DEPTH; a++) begin
      idle_in(); adr_ld = 1; adr_in = a[AW-1:0]; gw_n = 0;
      dq_i = {a[8:0] ^ 9'h155, a[8:0]};
      tick("R4 fill");
    end
    for (int a = 0; a < DEPTH; a++) ref_mem[a] = {a[8:0] ^ 9'h155, a[8:0]};
    mem_known = 1;
    idle_in();
    load_read(8'd3, "R7 read after fill");

    // R5: lane A only then read at once (R7).
    idle_in(); adr_ld = 1; adr_in = 8'd5; bwe_n = 0; bw_n = 2'b10; dq_i = 18'h3ffff;
    tick("R5 lane A write");
    load_read(8'd5, "R5 lane B kept");
    idle_in(); adr_ld = 1; adr_in = 8'd6; bwe_n = 0; bw_n = 2'b01; dq_i = 18'h2aaaa;
    tick("R5 lane B write");
    load_read(8'd6, "R5 lane A kept");

    // R6: qualifier low but no lane enable -> read, drives bus.
    idle_in(); adr_ld = 1; adr_in = 8'd7; bwe_n = 0; bw_n = 2'b11; dq_i = 18'h01234;
    tick("R6 read with qualifier");
    idle_in(); adr_ld = 1; adr_in = 8'd7; bw_n = 2'b00; dq_i = 18'h01234;
    tick("R6 read with enables, qualifier high");
    load_read(8'd7, "R6 word unchanged");

    // R4: global write ignores byte controls. R8: oe_n low during write.
    idle_in(); adr_ld = 1; adr_in = 8'd9; gw_n = 0; bwe_n = 1; bw_n = 2'b11; dq_i = 18'h1c0de;
    tick("R4 R8 global write");
    load_read(8'd9, "R4 readback");

    // R2: deselecting load, then a write attempt while deselected.
    idle_in(); adr_ld = 1; adr_in = 8'd12; ce2 = 0;
    tick("R2 deselect");
    idle_in(); gw_n = 0; dq_i = 18'h3_0f0f; seq_ofs = 2'd0;
    tick("R2 no write while deselected");
    idle_in(); adr_ld = 1; adr_in = 8'd12; ce3_n = 1; gw_n = 0; dq_i = 18'h00bad;
    tick("R2 deselect via ce3_n");
    load_read(8'd12, "R2 word untouched");

    // R3 and R11: hold selection with bad enables, walk low bits from seq_ofs.
    load_read(8'd20, "R11 full load");
    for (int s = 1; s < 4; s++) begin
      idle_in(); ce1_n = 1; ce2 = 0; seq_ofs = s[1:0];
      tick("R3 R11 sequenced read");
    end

    // R9: oe_n between edges.
    load_read(8'd33, "R9 drive on");
    oe_n = 1; #0.5;
    check_bus("R9 oe_n high no clock");
    oe_n = 0; #0.5;
    check_bus("R9 oe_n low no clock");

    // R10: sleep between edges, then deselect, then exit.
    sleep = 1; #0.5;
    check_bus("R10 sleep async off");
    tick("R10 sleep sampled");
    sleep = 0; #0.5;
    check_bus("R10 stays off after exit");
    tick("R10 off until load");
    load_read(8'd33, "R10 reselect");

    // Random mix.
    for (int i = 0; i < 4000; i++) begin
      int r;
      idle_in();
      r = $urandom_range(0, 99);
      adr_ld  = (r < 30);
      adr_in  = AW'($urandom);
      seq_ofs = BW'($urandom);
      r = $urandom_range(0, 9);
      if (r == 0) ce1_n = 1;
      if (r == 1) ce2 = 0;
      if (r == 2) ce3_n = 1;
      gw_n  = ($urandom_range(0, 9) > 1);
      bwe_n = ($urandom_range(0, 9) > 3);
      bw_n  = 2'($urandom);
      oe_n  = ($urandom_range(0, 9) == 0);
      sleep = ($urandom_range(0, 49) == 0);
      dq_i  = 18'($urandom);
      tick("R7 random");
      if ($urandom_range(0, 19) == 0) begin
        oe_n = ~oe_n; #0.5;
        check_bus("R8 R9 random async");
      end
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule